// File: doc/BRIEF.md
# Serial Programming Enable Synchronizer

This block is the host side of an in-system serial programming link. On a start request it holds the target's reset line and serial clock low, then gives reset one positive pulse to recover a target whose clock line was not held low at power-up. It then waits a settling period and sends the four-byte programming-enable frame on MOSI, clocking it with a divided SCK. While the third byte goes out, it reads a byte back on MISO. If that byte is the expected echo, the link is in step and the block reports success with a one-cycle pulse.

When the echo is wrong, the frame is still sent to its end. The block then gives SCK one lone pulse, which moves the target's bit framing by one position, and sends the whole frame again. After a bounded number of frames with no echo it raises a sticky failure flag, which means no working target is attached. Once the link is in step, an erase request sends the chip-erase frame, waits the erase time, pulses reset and runs the whole synchronization again.

All timing is given in system clock cycles through parameters: the SCK half period, the reset pulse width, the settle wait (20 ms in a real system), the erase wait and the attempt limit.

Top module: `prog_sync_ctrl`

## Requirements
- R1: After reset, sck, mosi, tgt_reset, done and fail are 0 and attempts is 0.
- R2: A start request, accepted only when idle, synchronized or failed, drives tgt_reset high for exactly RST_CYC clocks while sck stays low. A start during a running sequence is ignored.
- R3: The first SCK rising edge follows the fall of tgt_reset by at least SETTLE_CYC clocks.
- R4: Each enable frame is 32 SCK pulses carrying the bytes 0xAC, 0x53, 0x00, 0x00, each byte MSB first. MOSI changes only while SCK is low.
- R5: Every SCK high phase lasts exactly HALF_DIV clocks, and every low phase lasts at least HALF_DIV clocks.
- R6: The echo is the 8 MISO bits sampled at SCK rising edges 17 to 24 of a frame, MSB first. If it equals 0x53, done pulses high for exactly one clock and no further SCK activity follows.
- R7: When the echo is wrong, the full frame is still sent, then exactly one extra SCK pulse with MOSI low, then a new full frame. A sequence that ends after n frames therefore shows 33n-1 SCK rising edges.
- R8: After MAX_TRIES (default 32) frames without a correct echo, fail goes high and stays high, with no SCK or reset activity, until the next start, which clears it. A correct echo on the last allowed frame still counts as success.
- R9: attempts holds the number of enable frames begun in the current sequence. It is cleared on each start or post-erase restart and never exceeds MAX_TRIES.
- R10: An erase request while synchronized sends the frame 0xAC, 0x80, 0x00, 0x00. It then keeps SCK low for at least ERASE_CYC clocks, pulses tgt_reset once, and repeats the settle and enable sequence with attempts restarted.
- R11: An erase request while not synchronized is ignored: no reset pulse and no SCK edge follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin reset, settle and enable sequence |
| erase_req | input | 1 | Erase the target and resynchronize (synchronized state only) |
| miso | input | 1 | Serial data from the target |
| tgt_reset | output | 1 | Reset line to the target, active high pulse |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| done | output | 1 | One-clock pulse when the echo is correct |
| fail | output | 1 | Sticky: no correct echo within MAX_TRIES frames |
| attempts | output | ATT_W (6) | Enable frames begun in the current sequence |

## Verification
The bench's target model frames bits on its own counter, which starts at a chosen offset from the host's first edge. It echoes only when its framing lines up. Offset 0 checks the first-frame path. Offsets 31 and 30 check one and two framing slides. Offset 16 checks a long retry run. Offset 1 succeeds only on the thirty-second frame, which tells a correct limit apart from an early give-up. A target that never answers checks the failure path and the rising-edge count that grows with each frame. An erase run against a target whose offset changes across the reset checks the erase frame, the wait, the restart of the attempt count, and that erase and start requests made in the wrong state are ignored.

// File: rtl/prog_sync_pkg.sv
// Shared types and frame constants for the serial programming synchronizer.
package prog_sync_pkg;

    localparam int          FRAME_W    = 32;
    localparam int          ECHO_LSB   = 8;      // third byte sits at [15:8]
    localparam logic [31:0] ENABLE_FRM = 32'hAC53_0000;
    localparam logic [31:0] ERASE_FRM  = 32'hAC80_0000;
    localparam logic [7:0]  ECHO_VAL   = 8'h53;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST,
        S_SETTLE,
        S_SEND,
        S_JUDGE,
        S_NUDGE,
        S_READY,
        S_ERSEND,
        S_ERWAIT,
        S_FAIL
    } seq_state_t;

endpackage

// File: rtl/prog_sync_timer.sv
// Down-counting delay timer shared by the reset, settle and erase waits.
// Assumes: the loaded value is the wait length minus one; expired is high
// while the count is zero, so a wait state lasts load_val+1 clocks.
module prog_sync_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Load a new wait or count the running one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/prog_sync_shifter.sv
// Serial frame engine: sends a WORD_W-bit frame MSB first, or a single
// framing-slide pulse with MOSI low. Each SCK phase lasts HALF_DIV clocks.
// MOSI changes only at the falling edge or before the first rise. MISO is
// captured at each rising edge, by which time the target has updated it on
// the previous falling edge.
// Assumes: go and nudge are only raised while the engine is idle.
module prog_sync_shifter #(
    parameter int HALF_DIV = 4,
    parameter int WORD_W   = 32,
    parameter int ECHO_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              nudge,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              fin,
    output logic [7:0]        echo_byte
);

    localparam int HW  = $clog2(HALF_DIV + 1);
    localparam int BW  = $clog2(WORD_W + 1);
    localparam int RXW = ECHO_LSB + 8;

    logic              active_q;
    logic [HW-1:0]     hcnt_q;
    logic [BW-1:0]     left_q;
    logic [WORD_W-1:0] txs_q;
    logic [RXW-1:0]    rxs_q;
    logic              sck_q;
    logic              mosi_q;
    logic              fin_q;

    // Phase timing, bit shifting and MISO capture for one frame or pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hcnt_q   <= '0;
            left_q   <= '0;
            txs_q    <= '0;
            rxs_q    <= '0;
            sck_q    <= 1'b0;
            mosi_q   <= 1'b0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!active_q) begin
                if (go) begin
                    active_q <= 1'b1;
                    txs_q    <= tx_word << 1;
                    mosi_q   <= tx_word[WORD_W-1];
                    left_q   <= BW'(WORD_W);
                    hcnt_q   <= HW'(HALF_DIV - 1);
                end else if (nudge) begin
                    active_q <= 1'b1;
                    txs_q    <= '0;
                    mosi_q   <= 1'b0;
                    left_q   <= BW'(1);
                    hcnt_q   <= HW'(HALF_DIV - 1);
                end
            end else if (hcnt_q != '0) begin
                hcnt_q <= hcnt_q - 1'b1;
            end else begin
                hcnt_q <= HW'(HALF_DIV - 1);
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rxs_q <= {rxs_q[RXW-2:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (left_q == BW'(1)) begin
                        active_q <= 1'b0;
                        fin_q    <= 1'b1;
                        mosi_q   <= 1'b0;
                    end else begin
                        mosi_q <= txs_q[WORD_W-1];
                        txs_q  <= txs_q << 1;
                        left_q <= left_q - 1'b1;
                    end
                end
            end
        end
    end

    assign sck       = sck_q;
    assign mosi      = mosi_q;
    assign fin       = fin_q;
    assign echo_byte = rxs_q[RXW-1:ECHO_LSB];

endmodule

// File: rtl/prog_sync_seq.sv
// Sequencing state machine: reset pulse, settle wait, enable frames with
// echo check and framing-slide retries, attempt limit, and the erase-then-
// restart helper.
// Assumes: the timer and shifter respond in the cycle after load/go/nudge.
module prog_sync_seq
    import prog_sync_pkg::*;
#(
    parameter int RST_CYC    = 4,
    parameter int SETTLE_CYC = 20000,
    parameter int ERASE_CYC  = 10000,
    parameter int MAX_TRIES  = 32,
    parameter int TW         = 16,
    parameter int ATT_W      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               erase_req,
    input  logic               tmr_expired,
    input  logic               sh_fin,
    input  logic [7:0]         echo_byte,
    output logic               tmr_load,
    output logic [TW-1:0]      tmr_val,
    output logic               sh_go,
    output logic               sh_nudge,
    output logic [FRAME_W-1:0] tx_word,
    output logic               tgt_reset,
    output logic               done,
    output logic               fail,
    output logic [ATT_W-1:0]   attempts
);

    seq_state_t       st_q, st_d;
    logic             rst_q;
    logic             done_q;
    logic             fail_q;
    logic [ATT_W-1:0] att_q;
    logic             enter_rst;
    logic             new_frame;

    // Next state and the one-cycle commands to the timer and shifter.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_go    = 1'b0;
        sh_nudge = 1'b0;
        case (st_q)
            S_IDLE, S_FAIL: begin
                if (start) begin
                    st_d     = S_RST;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_CYC - 1);
                end
            end
            S_READY: begin
                if (start) begin
                    st_d     = S_RST;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_CYC - 1);
                end else if (erase_req) begin
                    st_d  = S_ERSEND;
                    sh_go = 1'b1;
                end
            end
            S_RST: begin
                if (tmr_expired) begin
                    st_d     = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETTLE_CYC - 1);
                end
            end
            S_SETTLE: begin
                if (tmr_expired) begin
                    st_d  = S_SEND;
                    sh_go = 1'b1;
                end
            end
            S_SEND: begin
                if (sh_fin) st_d = S_JUDGE;
            end
            S_JUDGE: begin
                if (echo_byte == ECHO_VAL) begin
                    st_d = S_READY;
                end else if (att_q == ATT_W'(MAX_TRIES)) begin
                    st_d = S_FAIL;
                end else begin
                    st_d     = S_NUDGE;
                    sh_nudge = 1'b1;
                end
            end
            S_NUDGE: begin
                if (sh_fin) begin
                    st_d  = S_SEND;
                    sh_go = 1'b1;
                end
            end
            S_ERSEND: begin
                if (sh_fin) begin
                    st_d     = S_ERWAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ERASE_CYC - 1);
                end
            end
            S_ERWAIT: begin
                if (tmr_expired) begin
                    st_d     = S_RST;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_CYC - 1);
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    assign tx_word   = (st_q == S_READY) ? ERASE_FRM : ENABLE_FRM;
    assign enter_rst = (st_d == S_RST) && (st_q != S_RST);
    assign new_frame = sh_go && (st_q != S_READY);

    // State register and registered status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            rst_q  <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            att_q  <= '0;
        end else begin
            st_q   <= st_d;
            rst_q  <= (st_d == S_RST);
            done_q <= (st_q == S_JUDGE) && (st_d == S_READY);
            if (enter_rst) begin
                fail_q <= 1'b0;
            end else if (st_d == S_FAIL) begin
                fail_q <= 1'b1;
            end
            if (enter_rst) begin
                att_q <= '0;
            end else if (new_frame) begin
                att_q <= att_q + 1'b1;
            end
        end
    end

    assign tgt_reset = rst_q;
    assign done      = done_q;
    assign fail      = fail_q;
    assign attempts  = att_q;

endmodule

// File: rtl/prog_sync_ctrl.sv
// Top of the serial programming enable synchronizer: ties the sequencer,
// the shared delay timer and the serial frame engine together.
// Assumes: all delays are in system clock cycles; HALF_DIV is chosen so that
// each SCK phase spans more than two target clock periods.
module prog_sync_ctrl
    import prog_sync_pkg::*;
#(
    parameter int HALF_DIV   = 4,
    parameter int RST_CYC    = 4,
    parameter int SETTLE_CYC = 20000,
    parameter int ERASE_CYC  = 10000,
    parameter int MAX_TRIES  = 32,
    localparam int ATT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             erase_req,
    input  logic             miso,
    output logic             tgt_reset,
    output logic             sck,
    output logic             mosi,
    output logic             done,
    output logic             fail,
    output logic [ATT_W-1:0] attempts
);

    localparam int TMAX_A = (SETTLE_CYC > ERASE_CYC) ? SETTLE_CYC : ERASE_CYC;
    localparam int TMAX   = (TMAX_A > RST_CYC) ? TMAX_A : RST_CYC;
    localparam int TW     = $clog2(TMAX + 1);

    logic               tmr_load;
    logic [TW-1:0]      tmr_val;
    logic               tmr_expired;
    logic               sh_go;
    logic               sh_nudge;
    logic               sh_fin;
    logic [FRAME_W-1:0] tx_word;
    logic [7:0]         echo_byte;

    prog_sync_seq #(
        .RST_CYC   (RST_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .ERASE_CYC (ERASE_CYC),
        .MAX_TRIES (MAX_TRIES),
        .TW        (TW),
        .ATT_W     (ATT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .erase_req  (erase_req),
        .tmr_expired(tmr_expired),
        .sh_fin     (sh_fin),
        .echo_byte  (echo_byte),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .sh_go      (sh_go),
        .sh_nudge   (sh_nudge),
        .tx_word    (tx_word),
        .tgt_reset  (tgt_reset),
        .done       (done),
        .fail       (fail),
        .attempts   (attempts)
    );

    prog_sync_timer #(
        .TW(TW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    prog_sync_shifter #(
        .HALF_DIV(HALF_DIV),
        .WORD_W  (FRAME_W),
        .ECHO_LSB(ECHO_LSB)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (sh_go),
        .nudge    (sh_nudge),
        .tx_word  (tx_word),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .fin      (sh_fin),
        .echo_byte(echo_byte)
    );

endmodule

// File: rtl/prog_sync_ctrl_chk.sv
// Protocol checker for prog_sync_ctrl, attached to it through bind.
// Assumes: the same HALF_DIV and MAX_TRIES values as the checked instance.
module prog_sync_ctrl_chk #(
    parameter int HALF_DIV  = 4,
    parameter int MAX_TRIES = 32,
    parameter int ATT_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck,
    input logic             mosi,
    input logic             tgt_reset,
    input logic             done,
    input logic             fail,
    input logic [ATT_W-1:0] attempts
);

    int unsigned hi_run;

    // Length of the current SCK high phase in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= 0;
        end else if (sck) begin
            hi_run <= hi_run + 1;
        end else begin
            hi_run <= 0;
        end
    end

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R2
    rst_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset |-> !sck);

    // R5
    sck_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= HALF_DIV);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R8
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!sck && !tgt_reset));

    // R9
    attempts_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= ATT_W'(MAX_TRIES));

endmodule

bind prog_sync_ctrl prog_sync_ctrl_chk #(
    .HALF_DIV (HALF_DIV),
    .MAX_TRIES(MAX_TRIES),
    .ATT_W    (ATT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .mosi     (mosi),
    .tgt_reset(tgt_reset),
    .done     (done),
    .fail     (fail),
    .attempts (attempts)
);

// File: tb/tb_prog_sync_ctrl.sv
module tb_prog_sync_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF   = 3;
    localparam int SETTLE = 40;
    localparam int ERASE  = 60;
    localparam int RSTC   = 4;
    localparam int MAXT   = 32;
    localparam int WD_CYC = 150000;

    // Each row: target offset, dead target, expected attempts, expected fail
    localparam int VEC [6][4] = '{
        '{0,  0, 1,  0},
        '{31, 0, 2,  0},
        '{30, 0, 3,  0},
        '{16, 0, 17, 0},
        '{0,  1, 32, 1},
        '{1,  0, 32, 0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       erase_req = 1'b0;
    logic       miso = 1'b0;
    logic       tgt_reset, sck, mosi, done, fail;
    logic [5:0] attempts;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_sync_ctrl #(
        .HALF_DIV  (HALF),
        .RST_CYC   (RSTC),
        .SETTLE_CYC(SETTLE),
        .ERASE_CYC (ERASE),
        .MAX_TRIES (MAXT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .erase_req(erase_req),
        .miso(miso), .tgt_reset(tgt_reset), .sck(sck), .mosi(mosi),
        .done(done), .fail(fail), .attempts(attempts)
    );

    // Target model: frames bits on its own counter, starting at tgt_off,
    // and echoes byte two during byte three only when its framing lines up.
    int         tgt_off = 0;
    logic       tgt_dead = 1'b0;
    logic [4:0] t_c;
    logic [15:0] t_sr;
    logic [7:0] t_b1;
    logic       t_arm;

    always @(posedge sck or posedge tgt_reset) begin
        if (tgt_reset) begin
            t_c   <= 5'(tgt_off);
            t_sr  <= '0;
            t_b1  <= '0;
            t_arm <= 1'b0;
        end else begin
            t_sr <= {t_sr[14:0], mosi};
            if (t_c == 5'd15) begin
                t_arm <= ({t_sr[14:0], mosi} == 16'hAC53) && !tgt_dead;
                t_b1  <= {t_sr[6:0], mosi};
            end else if (t_c == 5'd31) begin
                t_arm <= 1'b0;
            end
            t_c <= t_c + 5'd1;
        end
    end

    always @(negedge sck or posedge tgt_reset) begin
        if (tgt_reset) miso <= 1'b0;
        else if (t_arm && t_c >= 5'd16 && t_c <= 5'd23) miso <= t_b1[3'(23 - int'(t_c))];
        else miso <= 1'b0;
    end

    // Port monitor, sampled on the falling clock edge.
    logic        mon_clr = 1'b0;
    int          edges, rst_pulses, rst_w, rst_run, hi_run, lo_run;
    int          width_bad, mosi_bad, done_cnt, settle_gap, since_rf;
    int          quiet_gap, since_fall;
    logic        settle_armed;
    logic [31:0] shreg, first_word;
    logic        p_sck = 1'b0, p_mosi = 1'b0, p_rst = 1'b0;

    always @(negedge clk) begin
        if (mon_clr) begin
            edges <= 0; rst_pulses <= 0; rst_w <= 0; rst_run <= 0;
            hi_run <= 0; lo_run <= 1000; width_bad <= 0; mosi_bad <= 0;
            done_cnt <= 0; settle_gap <= 0; since_rf <= 0; quiet_gap <= 0;
            since_fall <= 0; settle_armed <= 1'b0; shreg <= '0; first_word <= '0;
        end else begin
            if (tgt_reset && !p_rst) quiet_gap <= since_fall;
            if (tgt_reset) rst_run <= rst_run + 1;
            if (!tgt_reset && p_rst) begin
                rst_pulses <= rst_pulses + 1;
                rst_w <= rst_run;
                rst_run <= 0;
                since_rf <= 0;
                settle_armed <= 1'b1;
            end else begin
                since_rf <= since_rf + 1;
            end
            if (sck && !p_sck) begin
                edges <= edges + 1;
                shreg <= {shreg[30:0], mosi};
                if (edges == 31) first_word <= {shreg[30:0], mosi};
                if (lo_run < HALF) width_bad <= width_bad + 1;
                if (settle_armed) begin
                    settle_gap <= since_rf + 1;
                    settle_armed <= 1'b0;
                end
                hi_run <= 1;
            end else if (sck) begin
                hi_run <= hi_run + 1;
            end
            if (!sck && p_sck) begin
                if (hi_run != HALF) width_bad <= width_bad + 1;
                lo_run <= 1;
                since_fall <= 1;
            end else if (!sck) begin
                lo_run <= lo_run + 1;
                since_fall <= since_fall + 1;
            end
            if (sck && p_sck && (mosi != p_mosi)) mosi_bad <= mosi_bad + 1;
            if (done) done_cnt <= done_cnt + 1;
        end
        p_sck  <= sck;
        p_mosi <= mosi;
        p_rst  <= tgt_reset;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input int act, input int lim);
        checks++;
        if (act < lim) begin
            failures++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_mon();
        tick(1); mon_clr = 1'b1;
        tick(1); mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        tick(1); start = 1'b1;
        tick(1); start = 1'b0;
    endtask

    task automatic pulse_erase();
        tick(1); erase_req = 1'b1;
        tick(1); erase_req = 1'b0;
    endtask

    task automatic wait_end();
        int n = 0;
        tick(2);
        while (done_cnt == 0 && !fail && n < 20000) begin
            tick(1);
            n++;
        end
        tick(3);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sck", 32'(sck), 0);
        chk("R1 mosi", 32'(mosi), 0);
        chk("R1 tgt_reset", 32'(tgt_reset), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 fail", 32'(fail), 0);
        chk("R1 attempts", 32'(attempts), 0);

        // R11: erase request while idle is ignored
        clear_mon();
        pulse_erase();
        tick(100);
        chk("R11 idle edges", 32'(edges), 0);
        chk("R11 idle resets", 32'(rst_pulses), 0);

        for (int i = 0; i < 6; i++) begin
            tgt_off  = VEC[i][0];
            tgt_dead = VEC[i][1];
            clear_mon();
            pulse_start();
            wait_end();
            @(negedge clk);
            chk("R9 attempts", 32'(attempts), 32'(VEC[i][2]));
            chk("R8 fail", 32'(fail), 32'(VEC[i][3]));
            chk("R6 done count", 32'(done_cnt), 32'(1 - VEC[i][3]));
            chk("R7 rising edges", 32'(edges), 32'(33 * VEC[i][2] - 1));
            chk("R4 first frame", first_word, 32'hAC53_0000);
            chk("R4 mosi stable", 32'(mosi_bad), 0);
            chk("R5 phase widths", 32'(width_bad), 0);
            chk("R2 reset width", 32'(rst_w), 32'(RSTC));
            chk_ge("R3 settle gap", settle_gap, SETTLE);
            if (VEC[i][3] != 0) begin
                // R8 quiet while failed; R11 erase ignored when failed
                pulse_erase();
                tick(200);
                chk("R8 quiet edges", 32'(edges), 32'(33 * VEC[i][2] - 1));
                chk("R11 fail resets", 32'(rst_pulses), 1);
                chk("R8 fail held", 32'(fail), 1);
            end
        end

        // R10 erase then restart; target framing changes across the reset
        tgt_off = 31;
        clear_mon();
        pulse_erase();
        wait_end();
        @(negedge clk);
        chk("R10 erase frame", first_word, 32'hAC80_0000);
        chk("R10 reset pulses", 32'(rst_pulses), 1);
        chk("R10 attempts restart", 32'(attempts), 2);
        chk("R10 edges", 32'(edges), 32 + 65);
        chk_ge("R10 erase wait", quiet_gap, ERASE);
        chk("R10 done", 32'(done_cnt), 1);

        // R2: a second start during the sequence is ignored
        clear_mon();
        pulse_start();
        tick(20);
        pulse_start();
        wait_end();
        @(negedge clk);
        chk("R2 busy start resets", 32'(rst_pulses), 1);
        chk("R9 busy attempts", 32'(attempts), 2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule